// File: doc/BRIEF.md
# Line Sync Phase-Detector Gate Controller

This block drives the digital controls of a horizontal phase-locked loop in a video sync processor. A line-start pulse from the line oscillator restarts a cycle counter. The expected sync edge sits a fixed number of cycles after that pulse. At each line start the block samples four things: the vertical-retrace flag, the noise-detected flag, the video-present flag and the register override bits. From them it produces four outputs: a phase-detector conduction window, a loop time-constant select, a detector current boost enable and a loop enable.

With a clean signal outside retrace, the detector conducts for the whole line. During retrace it conducts only inside a wide window of about 22 µs placed unevenly around sync, which keeps out disturbances on the scan lines. When the noise flag is set, the window narrows to about 5.7 µs and is applied on every line. The time constant becomes slow under noise unless a register override fixes it. Only a fast loop gets the current boost, and only during retrace. A video-identification input can open the loop, and a decouple bit can stop it from doing so. All window offsets are clock-cycle counts derived from the system clock frequency parameter.

Top module: `hpll_gate_ctrl`

## Requirements
- R1: With override code 2'b00 or 2'b11 (automatic), `slow_o` is 1 for a line whose start sampled `noise_i`=1, and 0 otherwise.
- R2: Override code 2'b01 forces `slow_o`=1 and code 2'b10 forces `slow_o`=0, whatever the noise flag.
- R3: `boost_o` is 1 exactly on lines sampled with `vretrace_i`=1 whose `slow_o` is 0; it is never 1 together with `slow_o`.
- R4: On a line sampled with `noise_i`=0 and `vretrace_i`=0, `pd_win_o` stays 1 for the whole line.
- R5: On a line sampled with `noise_i`=0 and `vretrace_i`=1, `pd_win_o` is 1 only while the line counter c satisfies SYNC_POS-WIDE_PRE <= c < SYNC_POS+WIDE_POST. The counter is 0 in the cycle after the edge that samples `line_start_i`.
- R6: On a line sampled with `noise_i`=1, `pd_win_o` is 1 only while SYNC_POS-NARROW_PRE <= c < SYNC_POS+NARROW_POST. This holds whatever `vretrace_i` is.
- R7: `noise_i`, `vretrace_i` and `tc_mode_i` are sampled only on a clock edge with `line_start_i`=1. Changes between line starts leave `pd_win_o`, `slow_o` and `boost_o` unchanged until the next line start.
- R8: `loop_en_o` equals `video_present_i | vid_decouple_i` as sampled on the previous clock edge.
- R9: Out of reset, before any line start: `pd_win_o`=1, `slow_o`=0, `boost_o`=0, `loop_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| line_start_i | input | 1 | one-cycle pulse at the start of each line |
| vretrace_i | input | 1 | vertical retrace interval in progress |
| noise_i | input | 1 | noise detector reports excess noise |
| video_present_i | input | 1 | video identification sees a signal |
| tc_mode_i | input | 2 | time-constant override: 00/11 auto, 01 slow, 10 fast |
| vid_decouple_i | input | 1 | keep loop closed regardless of video identification |
| pd_win_o | output | 1 | phase detector may conduct |
| slow_o | output | 1 | slow loop time constant selected |
| boost_o | output | 1 | detector current +50% |
| loop_en_o | output | 1 | loop closed |

## Verification
The assertions assume that `line_start_i` is a single-cycle pulse. They also assume that lines are longer than SYNC_POS+WIDE_POST cycles, so that a window always ends before the next line start. The stimulus keeps lines at a fixed 30 cycles and the longest window ends at cycle 25. The assertions further assume that the video flags are stable in reset. The bench holds every input at 0 until reset has been released.

// File: rtl/hpll_gate_pkg.sv
package hpll_gate_pkg;
  typedef enum logic [1:0] {
    TC_AUTO  = 2'b00,
    TC_SLOW  = 2'b01,
    TC_FAST  = 2'b10,
    TC_AUTO2 = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic noisy;
    logic retrace;
    logic slow;
  } line_cfg_t;
endpackage

// File: rtl/hpll_line_timer.sv
module hpll_line_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LIMIT = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  // saturates so a missing line start never reopens a window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= LIM;
    else if (start_i)     cnt_o <= '0;
    else if (cnt_o != LIM) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hpll_cfg_latch.sv
module hpll_cfg_latch
  import hpll_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       noise_i,
  input  logic       vretrace_i,
  input  logic [1:0] tc_mode_i,
  output line_cfg_t  cfg_o
);
  tc_mode_e  mode;
  line_cfg_t nxt;

  always_comb begin
    mode        = tc_mode_e'(tc_mode_i);
    nxt.noisy   = noise_i;
    nxt.retrace = vretrace_i;
    unique case (mode)
      TC_SLOW: nxt.slow = 1'b1;
      TC_FAST: nxt.slow = 1'b0;
      default: nxt.slow = noise_i;
    endcase
  end

  // per-line snapshot: a window in progress is never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_o <= '0;
    else if (start_i) cfg_o <= nxt;
  end
endmodule

// File: rtl/hpll_gate_window.sv
module hpll_gate_window
  import hpll_gate_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_POS    = 12,
  parameter int unsigned WIDE_PRE    = 9,
  parameter int unsigned WIDE_POST   = 13,
  parameter int unsigned NARROW_PRE  = 2,
  parameter int unsigned NARROW_POST = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  line_cfg_t        cfg_i,
  output logic             win_o
);
  localparam logic [CNT_W-1:0] W_LO = CNT_W'(SYNC_POS - WIDE_PRE);
  localparam logic [CNT_W-1:0] W_HI = CNT_W'(SYNC_POS + WIDE_POST);
  localparam logic [CNT_W-1:0] N_LO = CNT_W'(SYNC_POS - NARROW_PRE);
  localparam logic [CNT_W-1:0] N_HI = CNT_W'(SYNC_POS + NARROW_POST);

  logic in_wide, in_narrow, gated;

  always_comb begin
    in_wide   = (cnt_i >= W_LO) && (cnt_i < W_HI);
    in_narrow = (cnt_i >= N_LO) && (cnt_i < N_HI);
    gated     = cfg_i.noisy | cfg_i.retrace;
    win_o     = !gated || (cfg_i.noisy ? in_narrow : in_wide);
  end
endmodule

// File: rtl/hpll_gate_ctrl.sv
module hpll_gate_ctrl
  import hpll_gate_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 27_000_000,
  parameter int unsigned LINE_MAX_US = 70,
  parameter int unsigned SYNC_POS    = CLK_HZ / 1_000_000 * 12,
  parameter int unsigned WIDE_PRE    = CLK_HZ / 1_000_000 * 9,
  parameter int unsigned WIDE_POST   = CLK_HZ / 1_000_000 * 13,
  parameter int unsigned NARROW_PRE  = CLK_HZ / 1_000_000 * 2,
  parameter int unsigned NARROW_POST = CLK_HZ / 100_000 * 37 / 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic       vretrace_i,
  input  logic       noise_i,
  input  logic       video_present_i,
  input  logic [1:0] tc_mode_i,
  input  logic       vid_decouple_i,
  output logic       pd_win_o,
  output logic       slow_o,
  output logic       boost_o,
  output logic       loop_en_o
);
  localparam int unsigned LINE_LIM = CLK_HZ / 1_000_000 * LINE_MAX_US;
  localparam int unsigned CNT_W    = $clog2(LINE_LIM + 1);

  logic [CNT_W-1:0] cnt;
  line_cfg_t        cfg;

  hpll_line_timer #(.CNT_W(CNT_W), .LIMIT(LINE_LIM)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(line_start_i),
    .cnt_o  (cnt)
  );

  hpll_cfg_latch u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (line_start_i),
    .noise_i   (noise_i),
    .vretrace_i(vretrace_i),
    .tc_mode_i (tc_mode_i),
    .cfg_o     (cfg)
  );

  hpll_gate_window #(
    .CNT_W      (CNT_W),
    .SYNC_POS   (SYNC_POS),
    .WIDE_PRE   (WIDE_PRE),
    .WIDE_POST  (WIDE_POST),
    .NARROW_PRE (NARROW_PRE),
    .NARROW_POST(NARROW_POST)
  ) u_win (
    .cnt_i(cnt),
    .cfg_i(cfg),
    .win_o(pd_win_o)
  );

  assign slow_o  = cfg.slow;
  assign boost_o = !cfg.slow && cfg.retrace;

  // video identification runs independent of line timing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loop_en_o <= 1'b0;
    else         loop_en_o <= video_present_i | vid_decouple_i;
  end
endmodule

// File: rtl/hpll_gate_ctrl_chk.sv
module hpll_gate_ctrl_chk #(
  parameter int unsigned WIDE_W   = 22,
  parameter int unsigned NARROW_W = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_start_i,
  input logic video_present_i,
  input logic vid_decouple_i,
  input logic pd_win_o,
  input logic slow_o,
  input logic boost_o,
  input logic loop_en_o
);
  logic [15:0] run_q;
  logic        past_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= '0;
      past_valid_q <= 1'b0;
    end else begin
      past_valid_q <= 1'b1;
      if (!pd_win_o)          run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + 1'b1;
    end
  end

  assert_no_boost_when_slow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_o |-> !slow_o);

  assert_mode_held_in_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_start_i) |-> ($stable(slow_o) && $stable(boost_o)));

  // R6 shares this check: a window that closes mid-line has one of the two widths
  assert_gate_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_win_o && $past(pd_win_o) && !$past(line_start_i))
      |-> (run_q == 16'(WIDE_W) || run_q == 16'(NARROW_W)));

  assert_loop_follows_video_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q |-> (loop_en_o == $past(video_present_i | vid_decouple_i)));
endmodule

bind hpll_gate_ctrl hpll_gate_ctrl_chk #(
  .WIDE_W  (WIDE_PRE + WIDE_POST),
  .NARROW_W(NARROW_PRE + NARROW_POST)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .line_start_i   (line_start_i),
  .video_present_i(video_present_i),
  .vid_decouple_i (vid_decouple_i),
  .pd_win_o       (pd_win_o),
  .slow_o         (slow_o),
  .boost_o        (boost_o),
  .loop_en_o      (loop_en_o)
);

// File: tb/hpll_gate_ctrl_test.sv
module hpll_gate_ctrl_test;
  localparam int LINE_LEN = 30;
  // CLK_HZ = 1 MHz in the model: sync at 12, wide [3,25), narrow [10,15)
  localparam int SYNC = 12, WPRE = 9, WPOST = 13, NPRE = 2, NPOST = 3;

  typedef struct {
    logic  win, slow, boost, loop_en;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 0, vretrace = 0, noise = 0, vid = 0, dec = 0;
  logic [1:0] mode = 2'b00;
  logic pd_win, slow, boost, loop_en;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  hpll_gate_ctrl #(.CLK_HZ(1_000_000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start),
    .vretrace_i(vretrace), .noise_i(noise), .video_present_i(vid),
    .tc_mode_i(mode), .vid_decouple_i(dec),
    .pd_win_o(pd_win), .slow_o(slow), .boost_o(boost), .loop_en_o(loop_en)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // driver: starts a line, pushes expected outputs for each of its cycles
  task automatic run_line(logic nz, logic rt, logic [1:0] md, logic v, logic d,
                          bit flip, string tag);
    logic sl, gated;
    noise = nz; vretrace = rt; mode = md; vid = v; dec = d; line_start = 1;
    sl    = (md == 2'b01) ? 1'b1 : (md == 2'b10) ? 1'b0 : nz;
    gated = nz | rt;
    @(posedge clk); #1;
    for (int c = 0; c < LINE_LEN; c++) begin
      exp_t e;
      if (!gated)  e.win = 1'b1;
      else if (nz) e.win = (c >= SYNC - NPRE) && (c < SYNC + NPOST);
      else         e.win = (c >= SYNC - WPRE) && (c < SYNC + WPOST);
      e.slow = sl; e.boost = !sl && rt; e.loop_en = v | d; e.tag = tag;
      q.push_back(e);
    end
    for (int c = 0; c < LINE_LEN; c++) begin
      @(negedge clk);
      if (c == 0) line_start = 0;
      if (flip && c == 10) begin
        noise = ~nz; vretrace = ~rt; mode = ~md;
      end
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, pd_win,  e.win,     "pd_win");
        check(e.tag, slow,    e.slow,    "slow");
        check(e.tag, boost,   e.boost,   "boost");
        check(e.tag, loop_en, e.loop_en, "loop_en");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R9", pd_win,  1'b1, "reset pd_win");
    check("R9", slow,    1'b0, "reset slow");
    check("R9", boost,   1'b0, "reset boost");
    check("R9", loop_en, 1'b0, "reset loop_en");
    @(negedge clk);
    run_line(0, 0, 2'b00, 1, 0, 0, "R4 R1 clean scan");
    run_line(0, 1, 2'b00, 1, 0, 0, "R5 R3 clean retrace");
    run_line(1, 0, 2'b00, 0, 0, 0, "R6 R1 R8 noisy scan");
    run_line(1, 1, 2'b00, 0, 1, 0, "R6 R3 R8 noisy retrace decoupled");
    run_line(0, 1, 2'b01, 1, 0, 0, "R2 forced slow");
    run_line(1, 1, 2'b10, 1, 0, 0, "R2 R3 forced fast");
    run_line(1, 0, 2'b11, 0, 0, 0, "R1 R2 alt auto code");
    run_line(0, 0, 2'b11, 1, 1, 0, "R1 R4 clean alt auto");
    run_line(0, 1, 2'b00, 1, 0, 1, "R7 mid-line change clean");
    run_line(1, 0, 2'b10, 0, 1, 1, "R7 mid-line change noisy");
    run_line(0, 0, 2'b00, 1, 0, 0, "R4 R7 after change");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    report();
  end
endmodule